// File: doc/BRIEF.md
# BCD Up/Down Event Counter with Compare Register

This block keeps a four-decade decimal event count (0000 to 9999) that steps up or down by one on each count event. A second four-digit register holds a compare value. The block drives one-hot digit strobes that cycle at a programmable rate. While a strobe is active, the block shows the matching counter digit on a 4-bit BCD output, and a bank of external switches puts the preset digit for that position on a shared active-low input bus.

A preset command (counter, register or both) is armed while its input is high and starts when the input is released. After release, the block waits for the start of a D1 strobe window and samples one digit at the end of each window, D1 through D4. At the end of the D4 window it writes all four digits at once. Two flags are available at all times: one reports that the counter equals the register, the other that the counter is zero. A third output, flags_valid, goes low for the whole length of a preset or clear operation.

Counting, presetting and clearing are plain level or pulse controls with no back-pressure. A count event that arrives while the block is busy is dropped, not held. The digit bus is sampled on a fixed schedule and has no handshake.

Top module: `bcd_tally_cmp`

## Requirements
- R1: After reset the counter and the register hold 0000, the strobe is 4'b0001 (D1), flags_valid is 1, and eq_flag and zero_flag are both 1.
- R2: In the idle state with no command, a high cnt_evt at a clock edge adds one (cnt_down=0) or subtracts one (cnt_down=1). A decade carries into the next decade only when it rolls from 9 to 0, and borrows only when it rolls from 0 to 9.
- R3: Counting up from 9999 gives 0000, and counting down from 0000 gives 9999.
- R4: Exactly one strobe bit is high at any time. Strobe bit k selects decade k, with bit 0 as the least significant decade. Each strobe lasts scan_div+1 cycles and the order is D1, D2, D3, D4, D1. bcd_out shows the selected counter digit, active-high.
- R5: A preset starts only after its command input is released. Sampling begins with the next complete D1 window. One digit is sampled in the last cycle of each window, and all four digits are written together at the end of the D4 window.
- R6: The input bus is active-low, so the digit value is the inverse of bcd_in_n. A bus that reads all ones gives digit 0. Any inverted value above 9 is stored as 9.
- R7: ld_cnt alone presets the counter and ld_reg alone presets the register. If both are high in the same cycle, or both are high at any point while the command is armed, both the counter and the register receive the same scanned value.
- R8: flags_valid is low from the cycle after a preset or clear command is accepted until that operation completes. eq_flag is 1 exactly when every counter decade equals the matching register decade. zero_flag is 1 exactly when the counter reads 0000.
- R9: zero_cmd clears the counter to 0000 at the edge where it is accepted and leaves the register unchanged. The block stays busy until zero_cmd is released.
- R10: While a preset or clear is in progress, count events and new ld_cnt, ld_reg or zero_cmd inputs have no effect.
- R11: When commands arrive together in the idle state, zero_cmd wins over a preset command, and a preset command wins over a count event. The losing inputs are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_div | input | DIVW (8) | Strobe period minus one, in clock cycles |
| cnt_evt | input | 1 | Count event, one step per high cycle |
| cnt_down | input | 1 | Direction for the event: 1 counts down |
| ld_cnt | input | 1 | Preset-counter command, acts on release |
| ld_reg | input | 1 | Preset-register command, acts on release |
| zero_cmd | input | 1 | Clear the counter to 0000 |
| bcd_in_n | input | 4 | Shared preset digit bus, active-low |
| strobe | output | NDIG (4) | One-hot digit strobes |
| bcd_out | output | 4 | Counter digit for the active strobe, active-high |
| eq_flag | output | 1 | Counter equals register |
| zero_flag | output | 1 | Counter is 0000 |
| flags_valid | output | 1 | Flags can be trusted (no preset or clear in progress) |

## Verification
A corrupted counter shows on bcd_out within one full strobe rotation, which is 4*(scan_div+1) cycles. The bench therefore reads a whole rotation before it compares a value. A wrong register has no direct output and appears only through eq_flag, so the bench steers the counter onto the expected register value and checks that eq_flag rises. A preset sequencer that is stuck or scans the digits out of order shows up in two ways: flags_valid fails to return within a few rotations, or decades come back permuted.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;
  typedef logic [3:0] bcd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SCAN = 2'd2,
    ST_CLR  = 2'd3
  } seq_st_e;

  // Active-low bus value to a legal decimal digit (values above nine saturate).
  function automatic bcd_t bus_to_digit(input logic [3:0] raw_n);
    logic [3:0] v;
    v = ~raw_n;
    return (v > 4'd9) ? 4'd9 : v;
  endfunction
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_tally_pkg::*;
(
  input  bcd_t d_i,
  input  logic step_i,
  input  logic down_i,
  output bcd_t d_o,
  output logic ripple_o
);
  always_comb begin
    d_o      = d_i;
    ripple_o = 1'b0;
    if (step_i) begin
      if (down_i) begin
        if (d_i == 4'd0) begin
          d_o      = 4'd9;
          ripple_o = 1'b1;
        end else begin
          d_o = d_i - 4'd1;
        end
      end else begin
        if (d_i >= 4'd9) begin
          d_o      = 4'd0;
          ripple_o = 1'b1;
        end else begin
          d_o = d_i + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner #(
  parameter int NDIG = 4,
  parameter int DIVW = 8,
  localparam int IW  = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o,
  output logic [IW-1:0]   idx_o,
  output logic [NDIG-1:0] strobe_o
);
  localparam logic [IW-1:0] LAST = IW'(NDIG - 1);

  logic [DIVW-1:0] pc_q;
  logic [IW-1:0]   idx_q;

  assign tick_o = (pc_q >= div_i);
  assign idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      idx_q <= '0;
    end else if (tick_o) begin
      pc_q  <= '0;
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_strobe
    assign strobe_o[g] = (idx_q == IW'(g));
  end
endmodule

// File: rtl/load_seq.sv
module load_seq
  import bcd_tally_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int IW  = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_cnt_i,
  input  logic            ld_reg_i,
  input  logic            clr_i,
  input  logic            evt_i,
  input  logic            tick_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [3:0]      bus_n_i,
  output logic            busy_o,
  output logic            cnt_we_o,
  output logic            reg_we_o,
  output logic            clr_o,
  output logic            step_o,
  output logic [NDIG*4-1:0] load_val_o
);
  localparam logic [IW-1:0] LAST = IW'(NDIG - 1);

  seq_st_e    st_q, st_d;
  logic [1:0] tgt_q, tgt_d;   // bit 1: counter, bit 0: register
  logic       go_q, go_d;     // a D1 window has begun
  bcd_t       shadow_q [NDIG];

  assign busy_o = (st_q != ST_IDLE);

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    go_d     = go_q;
    clr_o    = 1'b0;
    step_o   = 1'b0;
    cnt_we_o = 1'b0;
    reg_we_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (clr_i) begin
          clr_o = 1'b1;
          st_d  = ST_CLR;
        end else if (ld_cnt_i || ld_reg_i) begin
          st_d  = ST_ARM;
          tgt_d = {ld_cnt_i, ld_reg_i};
        end else begin
          step_o = evt_i;
        end
      end
      ST_ARM: begin
        tgt_d = tgt_q | {ld_cnt_i, ld_reg_i};
        if (!ld_cnt_i && !ld_reg_i) begin
          st_d = ST_SCAN;
          go_d = 1'b0;
        end
      end
      ST_SCAN: begin
        if (tick_i) begin
          if (go_q) begin
            if (idx_i == LAST) begin
              cnt_we_o = tgt_q[1];
              reg_we_o = tgt_q[0];
              st_d     = ST_IDLE;
            end
          end else if (idx_i == LAST) begin
            go_d = 1'b1;
          end
        end
      end
      ST_CLR: if (!clr_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tgt_q <= 2'b00;
      go_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      go_q  <= go_d;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[g] <= '0;
      end else if (st_q == ST_SCAN && tick_i && go_q && idx_i == IW'(g)) begin
        shadow_q[g] <= bus_to_digit(bus_n_i);
      end
    end
    if (g == NDIG - 1) begin : g_top
      assign load_val_o[g*4 +: 4] = bus_to_digit(bus_n_i);
    end else begin : g_low
      assign load_val_o[g*4 +: 4] = shadow_q[g];
    end
  end
endmodule

// File: rtl/bcd_tally_cmp.sv
module bcd_tally_cmp
  import bcd_tally_pkg::*;
#(
  parameter int NDIG = 4,
  parameter int DIVW = 8,
  localparam int IW  = $clog2(NDIG),
  localparam int VW  = NDIG * 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] scan_div,
  input  logic            cnt_evt,
  input  logic            cnt_down,
  input  logic            ld_cnt,
  input  logic            ld_reg,
  input  logic            zero_cmd,
  input  logic [3:0]      bcd_in_n,
  output logic [NDIG-1:0] strobe,
  output logic [3:0]      bcd_out,
  output logic            eq_flag,
  output logic            zero_flag,
  output logic            flags_valid
);
  logic          tick;
  logic [IW-1:0] idx;
  logic          busy, cnt_we, reg_we, clr, step;
  logic [VW-1:0] load_val, cnt_q, reg_q, cnt_nx;
  logic [NDIG:0] ripple;

  digit_scanner #(.NDIG(NDIG), .DIVW(DIVW)) u_scan (
    .clk(clk), .rst_n(rst_n), .div_i(scan_div),
    .tick_o(tick), .idx_o(idx), .strobe_o(strobe)
  );

  load_seq #(.NDIG(NDIG)) u_seq (
    .clk(clk), .rst_n(rst_n), .ld_cnt_i(ld_cnt), .ld_reg_i(ld_reg),
    .clr_i(zero_cmd), .evt_i(cnt_evt), .tick_i(tick), .idx_i(idx),
    .bus_n_i(bcd_in_n), .busy_o(busy), .cnt_we_o(cnt_we),
    .reg_we_o(reg_we), .clr_o(clr), .step_o(step), .load_val_o(load_val)
  );

  assign ripple[0] = step;
  for (genvar g = 0; g < NDIG; g++) begin : g_dec
    bcd_decade u_dec (
      .d_i(cnt_q[g*4 +: 4]), .step_i(ripple[g]), .down_i(cnt_down),
      .d_o(cnt_nx[g*4 +: 4]), .ripple_o(ripple[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (cnt_we) cnt_q <= load_val;
    else if (step)   cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_we) reg_q <= load_val;
  end

  always_comb begin
    bcd_out = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (idx == IW'(i)) bcd_out = cnt_q[i*4 +: 4];
    end
  end

  assign eq_flag     = (cnt_q == reg_q);
  assign zero_flag   = (cnt_q == '0);
  assign flags_valid = !busy;
endmodule

// File: rtl/bcd_tally_chk.sv
module bcd_tally_chk #(
  parameter int NDIG = 4,
  localparam int VW  = NDIG * 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDIG-1:0] strobe,
  input logic [VW-1:0]   cnt_q,
  input logic [VW-1:0]   reg_q,
  input logic            busy,
  input logic            cnt_evt,
  input logic            cnt_down,
  input logic            ld_cnt,
  input logic            ld_reg,
  input logic            zero_cmd,
  input logic            flags_valid
);
  localparam logic [VW-1:0] ALL9 = {NDIG{4'h9}};
  logic quiet_evt;
  assign quiet_evt = !busy && !zero_cmd && !ld_cnt && !ld_reg && cnt_evt;

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobe) == 1);

  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_evt && !cnt_down && cnt_q == ALL9) |=> cnt_q == '0);

  p_wrap_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_evt && cnt_down && cnt_q == '0) |=> cnt_q == ALL9);

  p_clear_keeps_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && zero_cmd) |=> (cnt_q == '0 && $stable(reg_q)));

  p_flags_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (zero_cmd || ld_cnt || ld_reg)) |=> !flags_valid);
endmodule

bind bcd_tally_cmp bcd_tally_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .cnt_q(cnt_q), .reg_q(reg_q),
  .busy(busy), .cnt_evt(cnt_evt), .cnt_down(cnt_down), .ld_cnt(ld_cnt),
  .ld_reg(ld_reg), .zero_cmd(zero_cmd), .flags_valid(flags_valid)
);

// File: tb/tb_bcd_tally_cmp.sv
`timescale 1ns/1ps
module tb_bcd_tally_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] scan_div = 8'd2;
  logic       cnt_evt = 0, cnt_down = 0, ld_cnt = 0, ld_reg = 0, zero_cmd = 0;
  logic [3:0] bcd_in_n;
  logic [3:0] strobe, bcd_out;
  logic       eq_flag, zero_flag, flags_valid;

  always #2.5 clk = ~clk;

  bcd_tally_cmp dut (
    .clk(clk), .rst_n(rst_n), .scan_div(scan_div), .cnt_evt(cnt_evt),
    .cnt_down(cnt_down), .ld_cnt(ld_cnt), .ld_reg(ld_reg), .zero_cmd(zero_cmd),
    .bcd_in_n(bcd_in_n), .strobe(strobe), .bcd_out(bcd_out),
    .eq_flag(eq_flag), .zero_flag(zero_flag), .flags_valid(flags_valid)
  );

  // Switch bank: raw digit values per strobe position, bus is active-low.
  logic [3:0] sw [4];
  function automatic int sidx(input logic [3:0] s);
    for (int i = 0; i < 4; i++) if (s[i]) return i;
    return 0;
  endfunction
  always_comb bcd_in_n = ~sw[sidx(strobe)];

  int checks = 0, errors = 0;
  int mcnt = 0, mreg = 0;
  bit done = 0;

  typedef struct { int cnt; bit eq; bit zr; string tag; } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver side: push the model's view and wait for the monitor to consume it.
  task automatic expect_now(input string tag);
    item_t it;
    it.cnt = mcnt; it.eq = (mcnt == mreg); it.zr = (mcnt == 0); it.tag = tag;
    sb.push_back(it);
    while (sb.size() > 0) @(negedge clk);
  endtask

  // Monitor: read one full display rotation and compare.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        int d [4];
        logic [3:0] seen;
        int val;
        it = sb[0];
        seen = '0;
        for (int n = 0; n < 40 && seen != 4'hF; n++) begin
          d[sidx(strobe)] = int'(bcd_out);
          seen[sidx(strobe)] = 1'b1;
          if (seen != 4'hF) @(negedge clk);
        end
        val = d[3]*1000 + d[2]*100 + d[1]*10 + d[0];
        chk(val == it.cnt, {it.tag, " count"}, val, it.cnt);
        chk(eq_flag == it.eq, {it.tag, " eq_flag"}, int'(eq_flag), int'(it.eq));
        chk(zero_flag == it.zr, {it.tag, " zero_flag"}, int'(zero_flag), int'(it.zr));
        chk(flags_valid == 1'b1, {it.tag, " flags_valid"}, int'(flags_valid), 1);
        void'(sb.pop_front());
      end
    end
  end

  task automatic set_sw(input int v);
    sw[0] = 4'(v % 10); sw[1] = 4'((v / 10) % 10);
    sw[2] = 4'((v / 100) % 10); sw[3] = 4'((v / 1000) % 10);
  endtask

  task automatic bump(input bit down, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_evt = 1; cnt_down = down;
      @(negedge clk); cnt_evt = 0;
      if (down) mcnt = (mcnt == 0) ? 9999 : mcnt - 1;
      else      mcnt = (mcnt == 9999) ? 0 : mcnt + 1;
    end
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (!flags_valid && n < 200) begin @(negedge clk); n++; end
    chk(flags_valid == 1'b1, {tag, " operation completes"}, int'(flags_valid), 1);
  endtask

  // Preset with the current switch settings; model update done by caller.
  task automatic preset(input bit lc, input bit lr, input string tag);
    @(negedge clk); ld_cnt = lc; ld_reg = lr;
    @(negedge clk); @(negedge clk);
    ld_cnt = 0; ld_reg = 0;
    @(negedge clk);
    chk(flags_valid == 1'b0, {tag, " R8 flags invalid during load"}, int'(flags_valid), 0);
    wait_idle(tag);
  endtask

  task automatic clear_cnt(input string tag);
    @(negedge clk); zero_cmd = 1;
    @(negedge clk);
    chk(flags_valid == 1'b0, {tag, " R9 busy during clear"}, int'(flags_valid), 0);
    zero_cmd = 0;
    wait_idle(tag);
    mcnt = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    set_sw(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(strobe == 4'b0001, "R1 strobe after reset", int'(strobe), 1);
    chk(flags_valid == 1'b1, "R1 flags_valid after reset", int'(flags_valid), 1);
    expect_now("R1 reset");

    // R4 strobe period and order
    n = 0;
    while (strobe != 4'b0010 && n < 50) begin @(negedge clk); n++; end
    n = 0;
    while (strobe == 4'b0010 && n < 50) begin @(negedge clk); n++; end
    chk(n == 3, "R4 strobe width", n, 3);
    chk(strobe == 4'b0100, "R4 strobe order", int'(strobe), 4);

    // R2 counting
    bump(0, 7);  expect_now("R2 up 7");
    bump(1, 3);  expect_now("R2 down 3");

    // R5 R6 R7 preset counter
    set_sw(9998); preset(1, 0, "R5 load cnt"); mcnt = 9998; expect_now("R5 R7 cnt 9998");
    bump(0, 1); expect_now("R2 9999");
    bump(0, 1); expect_now("R3 wrap up");
    bump(1, 1); expect_now("R3 wrap down");

    set_sw(999); preset(1, 0, "R2 carry"); mcnt = 999;
    bump(0, 1); expect_now("R2 carry 1000");
    bump(1, 1); expect_now("R2 borrow 0999");

    // R7 register only, R8 equality
    set_sw(42); preset(0, 1, "R7 load reg"); mreg = 42; expect_now("R7 reg only");
    set_sw(0); preset(1, 0, "R6 all open"); mcnt = 0; expect_now("R6 all-open is 0000");
    bump(0, 42); expect_now("R8 eq at 42");

    // R7 both in same cycle
    set_sw(1234); preset(1, 1, "R7 both"); mcnt = 1234; mreg = 1234; expect_now("R7 both same value");

    // R6 clamp: raw digits C,3,A,1 from D1 to D4 -> 1939
    sw[0] = 4'hC; sw[1] = 4'h3; sw[2] = 4'hA; sw[3] = 4'h1;
    preset(1, 0, "R6 clamp"); mcnt = 1939; expect_now("R6 clamp above nine");

    // R9 clear keeps register
    clear_cnt("R9 clear"); expect_now("R9 counter cleared reg kept");

    // R10 inputs ignored during a load
    set_sw(555);
    @(negedge clk); ld_cnt = 1;
    @(negedge clk); ld_cnt = 0;
    @(negedge clk); cnt_evt = 1; zero_cmd = 1; ld_reg = 1;
    @(negedge clk); cnt_evt = 0; zero_cmd = 0; ld_reg = 0;
    wait_idle("R10 load");
    mcnt = 555; expect_now("R10 busy inputs ignored");
    set_sw(1234); preset(1, 0, "R10 reg probe"); mcnt = 1234; expect_now("R10 register untouched");

    // R11 priority: clear over load over count
    @(negedge clk); zero_cmd = 1; ld_cnt = 1; cnt_evt = 1;
    @(negedge clk); zero_cmd = 0; ld_cnt = 0; cnt_evt = 0;
    wait_idle("R11 clear wins");
    mcnt = 0; expect_now("R11 clear beats load and count");
    set_sw(77);
    @(negedge clk); ld_cnt = 1; cnt_evt = 1;
    @(negedge clk); cnt_evt = 0; ld_cnt = 0;
    @(negedge clk);
    wait_idle("R11 load wins");
    mcnt = 77; expect_now("R11 load beats count");

    done = 1;
    finish_run();
  end
endmodule